// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single write requests from a synchronous host into the strobe sequence that an asynchronous, 16-bit, byte-laned SRAM-style memory needs. The host offers an address, a data word and two byte-enable bits with a valid/ready handshake. The sequencer captures them and drives the active-low chip select, the active-high second chip select, the active-low write strobe and the active-low upper and lower lane strobes. It also drives the enable of its own data drivers. Every interval is a whole number of clock cycles set by a parameter.

The memory's own output enable is assumed to be tied active for the whole time. This means the memory may drive the shared data pins whenever it is selected and not being written. The sequencer therefore decides when its data drivers may turn on. A build-time parameter selects one of two orderings. In the first, the write strobe opens and closes the write pulse. In the second, the chip select does. In the second ordering the memory never drives the pins, so no turnaround wait is needed.

Top module: `sram_wseq`

## Requirements
- R1: After reset `req_ready` is 1, `mem_cs_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are 1, and `mem_cs2` and `mem_dq_oe` are 0. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle completes.
- R2: `mem_addr` and `mem_dq_out` take the request's address and data at acceptance. They stay unchanged until `req_ready` returns, whatever the host inputs do in that time.
- R3: `req_be[1]` selects the upper lane (`mem_ub_n`) and `req_be[0]` selects the lower lane (`mem_lb_n`). A selected lane's strobe is low exactly while the chip-select/write-strobe pair is in its access window. An unselected lane's strobe stays 1.
- R4: `mem_cs2` is 1 in every cycle where `req_ready` is 0, and 0 otherwise.
- R5: With `CS_CTRL`=0, `mem_cs_n` and the selected lane strobes fall first. `mem_we_n` falls `T_AS` cycles later and stays low for max(`T_WP`, `T_WHZ`+`T_DS`) cycles. It then rises, and `mem_cs_n` and the lane strobes rise `T_DH` cycles after that.
- R6: With `CS_CTRL`=1, `mem_we_n` and the selected lane strobes fall first. `mem_cs_n` falls `T_AS` cycles later and stays low for max(`T_WP`, `T_DS`) cycles. It then rises, and `mem_we_n` and the lane strobes rise `T_DH` cycles after that.
- R7: With `CS_CTRL`=0, `mem_dq_oe` rises exactly `T_WHZ` cycles after `mem_we_n` falls. It stays 1 until `mem_cs_n` rises, so data is driven at least `T_DS` cycles before and `T_DH` cycles after the write strobe rises.
- R8: With `CS_CTRL`=1, `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and it only switches on while `mem_cs_n` is 1.
- R9: `req_ready` returns max(`T_WR`, `T_DH`+1) cycles after the write-ending strobe rises. For the last max(1, `T_WR`-`T_DH`) of those cycles, all active-low strobes are 1 and `mem_dq_oe` is 0.
- R10: A request with `req_be`=0 keeps `mem_we_n`, `mem_cs_n` and both lane strobes at 1 and `mem_dq_oe` at 0. It completes, with `req_ready` back to 1, max(1, `T_WR`-`T_DH`) cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | AW | Write address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| mem_addr | output | AW | Registered address to the memory |
| mem_dq_out | output | DW | Registered data to the pin drivers |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Second chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |

## Verification
The assertions check several local rules on every cycle:
- The host sees busy right after acceptance.
- Address and data hold while busy.
- The second chip select covers the busy period.
- The write strobe stays high when no lane is selected.
- Each mode keeps its ordering: which strobe rises first and which falls last.
- The data drivers switch on only once the memory can no longer be driving the pins.

The exact interval lengths cannot be checked that way: setup, pulse, turnaround, hold and recovery counts, the lane mapping, and the completion time of an empty request. The bench shows these by sweeping every byte-enable value in both orderings and comparing each pin on each cycle against counts computed from the parameters.

// File: rtl/sram_wseq_pkg.sv
// Shared types for the SRAM write sequencer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package sram_wseq_pkg;

    // Phase of one write cycle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV
    } wseq_state_e;

    // Larger of two counts, used for derived interval lengths.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wseq_timer.sv
// Phase timer: counts cycles spent in the current phase.
// Assumes restart is asserted on the cycle the phase changes; saturates at LIMIT-1.
module sram_wseq_timer #(
    parameter int unsigned CW    = 3,
    parameter int unsigned LIMIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);

    // Next count: zero on a phase change, otherwise step up to the saturation point.
    always_comb begin
        if (restart)                        cnt_nxt = '0;
        else if (cnt_q == CW'(LIMIT - 1))   cnt_nxt = cnt_q;
        else                                cnt_nxt = cnt_q + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/sram_wseq_capture.sv
// Request capture: holds address, data and lane selects for one write cycle.
// Assumes take is asserted only while the sequencer is idle.
module sram_wseq_capture #(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [1:0]    be_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [1:0]    be_q,
    output logic [1:0]    be_nxt
);

    // Lane selects as they will be after this edge, for registered strobe decode.
    assign be_nxt = take ? be_in : be_q;

    // Load the request fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (take) begin
            addr_q <= addr_in;
            data_q <= data_in;
            be_q   <= be_in;
        end
    end

endmodule

// File: rtl/sram_wseq_strobe.sv
// Strobe generator: decodes the next phase into memory strobes and registers them,
// so every pin comes straight from a flop. CS_CTRL picks which strobe bounds the pulse.
// Assumes T_WHZ is shorter than the write pulse in write-strobe-bounded mode.
module sram_wseq_strobe
    import sram_wseq_pkg::*;
#(
    parameter bit          CS_CTRL = 1'b0,
    parameter int unsigned T_WHZ   = 2,
    parameter int unsigned CW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wseq_state_e   state_nxt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [1:0]    be_nxt,
    output logic          mem_cs_n,
    output logic          mem_cs2,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic          mem_dq_oe
);

    logic access, cs_d, we_d, oe_d;

    // Access window: the phases in which lane strobes are active.
    assign access = (state_nxt == ST_SETUP) || (state_nxt == ST_PULSE) || (state_nxt == ST_HOLD);

    generate
        if (CS_CTRL) begin : g_cs_bound
            // Chip select bounds the pulse; the memory never drives, so data goes out at once.
            assign cs_d = (state_nxt == ST_PULSE);
            assign we_d = access;
            assign oe_d = access;
        end else begin : g_we_bound
            // Write strobe bounds the pulse; drivers wait out the turnaround after it falls.
            assign cs_d = access;
            assign we_d = (state_nxt == ST_PULSE);
            assign oe_d = ((state_nxt == ST_PULSE) && (cnt_nxt >= CW'(T_WHZ)))
                        || (state_nxt == ST_HOLD);
        end
    endgenerate

    // Output flops, inactive levels in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= ~cs_d;
            mem_cs2   <= (state_nxt != ST_IDLE);
            mem_we_n  <= ~we_d;
            mem_ub_n  <= ~(access & be_nxt[1]);
            mem_lb_n  <= ~(access & be_nxt[0]);
            mem_dq_oe <= oe_d;
        end
    end

    // R10: with no lane selected the write strobe never goes low.
    p_no_lane_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ub_n && mem_lb_n) |-> mem_we_n);

    generate
        if (CS_CTRL) begin : g_chk_cs
            // R6: chip select falls last, with the write strobe already low.
            p_cs_falls_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(mem_cs_n) |-> (!mem_we_n && $past(!mem_we_n)));
            // R6: write strobe rises only once chip select is high.
            p_we_rises_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_we_n) |-> mem_cs_n);
            // R8: drivers switch on only while the chip is deselected.
            p_oe_on_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_dq_oe) |-> mem_cs_n);
        end else begin : g_chk_we
            // R5: write strobe rises first, chip select still low.
            p_we_rises_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_we_n) |-> !mem_cs_n);
            // R5: chip select rises only after the write strobe.
            p_cs_rises_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_cs_n) |-> $past(mem_we_n));
            // R7: drivers switch on only after the write strobe has been low a cycle.
            p_oe_after_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));
        end
    endgenerate

endmodule

// File: rtl/sram_wseq.sv
// SRAM write sequencer top: host handshake, phase FSM and derived interval lengths.
// Assumes all interval parameters are at least 1 and the memory output enable is tied active.
module sram_wseq
    import sram_wseq_pkg::*;
#(
    parameter int unsigned AW      = 20,
    parameter int unsigned DW      = 16,
    parameter int unsigned T_AS    = 2,
    parameter int unsigned T_WP    = 3,
    parameter int unsigned T_WHZ   = 2,
    parameter int unsigned T_DS    = 2,
    parameter int unsigned T_DH    = 1,
    parameter int unsigned T_WR    = 3,
    parameter bit          CS_CTRL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    output logic          mem_cs_n,
    output logic          mem_cs2,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n
);

    localparam int unsigned P_LEN   = CS_CTRL ? umax(T_WP, T_DS) : umax(T_WP, T_WHZ + T_DS);
    localparam int unsigned R_LEN   = (T_WR > T_DH) ? (T_WR - T_DH) : 1;
    localparam int unsigned MAX_LEN = umax(umax(T_AS, P_LEN), umax(T_DH, R_LEN));
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    wseq_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_nxt, len_m1;
    logic [1:0]    be_q, be_nxt;
    logic          accept, last;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Final count of the current phase.
    always_comb begin
        unique case (state_q)
            ST_SETUP: len_m1 = CW'(T_AS - 1);
            ST_PULSE: len_m1 = CW'(P_LEN - 1);
            ST_HOLD:  len_m1 = CW'(T_DH - 1);
            ST_RECOV: len_m1 = CW'(R_LEN - 1);
            default:  len_m1 = '0;
        endcase
    end
    assign last = (cnt_q == len_m1);

    // Phase sequencing; an empty lane selection goes straight to recovery.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (|req_be) ? ST_SETUP : ST_RECOV;
            ST_SETUP: if (last)   state_d = ST_PULSE;
            ST_PULSE: if (last)   state_d = ST_HOLD;
            ST_HOLD:  if (last)   state_d = ST_RECOV;
            ST_RECOV: if (last)   state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    sram_wseq_timer #(.CW(CW), .LIMIT(MAX_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    sram_wseq_capture #(.AW(AW), .DW(DW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .be_in   (req_be),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_out),
        .be_q    (be_q),
        .be_nxt  (be_nxt)
    );

    sram_wseq_strobe #(.CS_CTRL(CS_CTRL), .T_WHZ(T_WHZ), .CW(CW)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_d),
        .cnt_nxt   (cnt_nxt),
        .be_nxt    (be_nxt),
        .mem_cs_n  (mem_cs_n),
        .mem_cs2   (mem_cs2),
        .mem_we_n  (mem_we_n),
        .mem_ub_n  (mem_ub_n),
        .mem_lb_n  (mem_lb_n),
        .mem_dq_oe (mem_dq_oe)
    );

    // R1: the host sees busy on the cycle after acceptance.
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2: address and data hold for the whole busy period.
    p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R4: second chip select covers every busy cycle and only those.
    p_cs2_tracks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs2 == !req_ready);

    // R3: lane strobes follow the captured lane selects.
    p_lane_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ub_n -> be_q[1]) && (!mem_lb_n -> be_q[0]));

endmodule

// File: tb/sram_wseq_bench.sv
// Bench: sweeps every lane selection in both orderings and compares each pin, each cycle,
// against interval counts derived from the parameters.
module sram_wseq_bench;

    localparam int AW = 20, DW = 16;
    localparam int T_AS = 2, T_WP = 3, T_WHZ = 2, T_DS = 2, T_DH = 1, T_WR = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          v_w, v_c, rdy_w, rdy_c;
    logic [AW-1:0] a_in, a_w, a_c;
    logic [DW-1:0] d_in, d_w, d_c;
    logic [1:0]    be_in;
    logic oe_w, cs_w, c2_w, we_w, ub_w, lb_w;
    logic oe_c, cs_c, c2_c, we_c, ub_c, lb_c;

    int n_chk = 0, n_fail = 0;

    sram_wseq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WHZ(T_WHZ), .T_DS(T_DS),
                .T_DH(T_DH), .T_WR(T_WR), .CS_CTRL(1'b0)) u_sram_wseq (
        .clk(clk), .rst_n(rst_n), .req_valid(v_w), .req_ready(rdy_w), .req_addr(a_in),
        .req_wdata(d_in), .req_be(be_in), .mem_addr(a_w), .mem_dq_out(d_w), .mem_dq_oe(oe_w),
        .mem_cs_n(cs_w), .mem_cs2(c2_w), .mem_we_n(we_w), .mem_ub_n(ub_w), .mem_lb_n(lb_w));

    sram_wseq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WHZ(T_WHZ), .T_DS(T_DS),
                .T_DH(T_DH), .T_WR(T_WR), .CS_CTRL(1'b1)) u_sram_wseq_cs (
        .clk(clk), .rst_n(rst_n), .req_valid(v_c), .req_ready(rdy_c), .req_addr(a_in),
        .req_wdata(d_in), .req_be(be_in), .mem_addr(a_c), .mem_dq_out(d_c), .mem_dq_oe(oe_c),
        .mem_cs_n(cs_c), .mem_cs2(c2_c), .mem_we_n(we_c), .mem_ub_n(ub_c), .mem_lb_n(lb_c));

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One request on the chosen instance, then a per-cycle comparison until idle.
    task automatic run_req(input bit cs_mode, input logic [AW-1:0] addr,
                           input logic [DW-1:0] data, input logic [1:0] be);
        int ts, tp, th, tr, act_end, tot;
        logic [6:0] obs, exp;
        logic [AW-1:0] oa;
        logic [DW-1:0] od;
        ts = T_AS; th = T_DH;
        tp = cs_mode ? imax(T_WP, T_DS) : imax(T_WP, T_WHZ + T_DS);
        tr = imax(1, T_WR - T_DH);
        act_end = ts + tp + th;
        tot = (be == 2'b00) ? tr : act_end + tr;
        @(negedge clk);
        a_in = addr; d_in = data; be_in = be;
        if (cs_mode) v_c = 1'b1; else v_w = 1'b1;
        check((cs_mode ? rdy_c : rdy_w) == 1'b1, "R1 ready before request",
              cs_mode ? rdy_c : rdy_w, 1);
        @(posedge clk);
        @(negedge clk);
        v_w = 1'b0; v_c = 1'b0;
        a_in = ~addr; d_in = ~data; be_in = ~be;   // R2: host inputs change while busy
        for (int k = 0; k <= tot; k++) begin
            logic e_cs, e_we, e_oe, e_act;
            e_act = (be != 2'b00) && (k < act_end);
            if (be == 2'b00) begin
                e_cs = 0; e_we = 0; e_oe = 0;
            end else if (cs_mode) begin
                e_we = e_act; e_cs = (k >= ts) && (k < ts + tp); e_oe = e_act;
            end else begin
                e_cs = e_act; e_we = (k >= ts) && (k < ts + tp);
                e_oe = (k >= ts + T_WHZ) && (k < act_end);
            end
            // order: ready, cs2, cs_n, we_n, ub_n, lb_n, oe
            exp = {k == tot, k < tot, !e_cs, !e_we, !(e_act && be[1]), !(e_act && be[0]), e_oe};
            obs = cs_mode ? {rdy_c, c2_c, cs_c, we_c, ub_c, lb_c, oe_c}
                          : {rdy_w, c2_w, cs_w, we_w, ub_w, lb_w, oe_w};
            oa = cs_mode ? a_c : a_w;
            od = cs_mode ? d_c : d_w;
            check(obs[6] == exp[6], (k == tot) ? "R9 ready return" : "R1 ready busy", obs[6], exp[6]);
            check(obs[5] == exp[5], "R4 cs2", obs[5], exp[5]);
            if (be == 2'b00)
                check(obs[4:0] == exp[4:0], "R10 empty request strobes", obs[4:0], exp[4:0]);
            else if (cs_mode)
                check(obs[4:3] == exp[4:3], "R6 cs/we ordering", obs[4:3], exp[4:3]);
            else
                check(obs[4:3] == exp[4:3], "R5 we/cs ordering", obs[4:3], exp[4:3]);
            check(obs[2:1] == exp[2:1], "R3 lane strobes", obs[2:1], exp[2:1]);
            if (cs_mode) check(obs[0] == exp[0], "R8 driver enable", obs[0], exp[0]);
            else         check(obs[0] == exp[0], "R7 driver enable", obs[0], exp[0]);
            check(oa == addr && od == data, "R2 captured fields", {oa, od}, {addr, data});
            if (k < tot) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        v_w = 0; v_c = 0; a_in = '0; d_in = '0; be_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on both instances
        check({rdy_w, cs_w, we_w, ub_w, lb_w, c2_w, oe_w} == 7'b1111100, "R1 reset state WE",
              {rdy_w, cs_w, we_w, ub_w, lb_w, c2_w, oe_w}, 7'b1111100);
        check({rdy_c, cs_c, we_c, ub_c, lb_c, c2_c, oe_c} == 7'b1111100, "R1 reset state CS",
              {rdy_c, cs_c, we_c, ub_c, lb_c, c2_c, oe_c}, 7'b1111100);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) begin
                run_req(m[0], 20'hA5A5A ^ AW'(b), 16'h1234 ^ DW'(b * 16'h0F0F), b[1:0]);
                run_req(m[0], 20'h0F0F0 + AW'(b), 16'hFEDC - DW'(b), b[1:0]);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule